// File: doc/BRIEF.md
# Gated Privilege Transition Controller

This controller moves a processor core between privilege levels (0 is the most privileged, 3 the least) only along defined paths. A caller asks to enter a more privileged level through one numbered gate of a small gate table. Each gate names a kind, a target segment, a target offset and the least privileged caller level that may use it. The controller checks the request and either refuses it with a protection fault that changes nothing, or carries it out. A successful entry saves the caller's context, switches to the stack held for the target ring when the level changes, and loads the new program counter, segment and level. The interrupt-enable flag is updated according to the gate kind.

Besides the gate path there is a fast system-call path, which ignores the gate table and jumps to a preconfigured entry address at level 0 on the level-0 stack. A fast return goes back to level 3. A general return restores the saved context exactly. Each operation runs through a short state sequence. A busy output covers the working cycles, and a one-cycle done pulse reports completion together with the fault flag.

Top module: `priv_gate_ctrl`

## Requirements
- R1: A gate request (req_op 0) is refused with fault=1 on the done pulse, and the level, stack pointer, program counter, segment and interrupt-enable flag stay unchanged, when any of these holds: the gate kind is 3 (reserved), the current level number is greater than the gate's minimum level, or the target level (bits 1:0 of the target segment) is numerically greater than the current level.
- R2: A successful entry through kind 1 (interrupt gate) clears int_en. Kinds 0 (call gate) and 2 (trap gate) leave int_en unchanged.
- R3: A successful gate entry sets cur_pc to the gate offset, cur_seg to the gate segment and cur_pl to bits 1:0 of that segment.
- R4: When a gate entry changes the level, cur_sp becomes the stack-table entry of the target ring. When the level stays the same, cur_sp is kept.
- R5: A successful gate or system-call entry saves the previous level, stack pointer, segment, interrupt-enable flag and the request's return address. A general return (req_op 3) restores all of them into cur_pl, cur_sp, cur_seg, int_en and cur_pc.
- R6: A fast system call (req_op 1) never faults and does not consult the gate table. It sets cur_pl to 0, cur_pc to syscall_entry, cur_sp to stack-table entry 0 and cur_seg to 16'h0008, and leaves int_en unchanged.
- R7: A fast return (req_op 2) from level 0 sets cur_pl to 3, cur_pc to the saved return address, cur_sp to the saved stack pointer, cur_seg to 16'h001B and int_en to 1. From any other level it faults and changes nothing.
- R8: A request is accepted only while the controller is idle. busy is high for 3 cycles after an accepted request that succeeds and for 1 cycle after one that faults, and then done is high for exactly one cycle. Requests made while busy or done is high are ignored.
- R9: After reset, cur_pl, cur_sp, cur_pc, cur_seg, int_en, busy, done and fault are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 gate entry, 1 fast system call, 2 fast return, 3 general return |
| req_gate | input | GIDX_W | Gate number for a gate entry |
| req_ret_pc | input | PC_W | Return address saved by an entry |
| gate_we | input | 1 | Gate table write enable |
| gate_waddr | input | GIDX_W | Gate table write index |
| gate_kind | input | 2 | Gate kind: 0 call, 1 interrupt, 2 trap, 3 reserved |
| gate_seg | input | SEG_W | Gate target segment, bits 1:0 give target level |
| gate_off | input | PC_W | Gate target offset |
| gate_min_pl | input | 2 | Least privileged caller level allowed |
| stk_we | input | 1 | Stack table write enable |
| stk_ring | input | 2 | Stack table ring index |
| stk_wdata | input | SP_W | Stack pointer for that ring |
| syscall_entry | input | PC_W | Fast system-call entry address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Protection fault, valid with done |
| cur_pl | output | 2 | Current privilege level |
| cur_sp | output | SP_W | Current stack pointer |
| cur_pc | output | PC_W | Current program counter |
| cur_seg | output | SEG_W | Current code segment |
| int_en | output | 1 | Interrupt-enable flag |

## Verification
A wrong eligibility verdict shows on the first done pulse, two cycles after the request is taken, as a fault flag with the wrong value or as a level change where none should occur. A wrong stack-table index or a skipped stack switch shows in cur_sp at the same done pulse. Corrupted shadow state stays hidden until the next return and only then appears as a wrong level, stack pointer or address, so every entry in the sequence is followed by a return. A broken sequencer shows as a busy window of the wrong length or as an extra done pulse after a request made while busy.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    parameter int PC_W  = 32;
    parameter int SP_W  = 32;
    parameter int SEG_W = 16;
    localparam int PL_W      = 2;
    localparam int NUM_RINGS = 1 << PL_W;

    localparam logic [SEG_W-1:0] KERNEL_SEG = 16'h0008;
    localparam logic [SEG_W-1:0] USER_SEG   = 16'h001B;
    localparam logic [PL_W-1:0]  USER_PL    = 2'd3;

    typedef enum logic [1:0] {
        OP_GATE    = 2'd0,
        OP_SYSCALL = 2'd1,
        OP_FRET    = 2'd2,
        OP_RET     = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        GK_CALL = 2'd0,
        GK_INTR = 2'd1,
        GK_TRAP = 2'd2,
        GK_RSVD = 2'd3
    } gkind_e;

    typedef struct packed {
        gkind_e            kind;
        logic [SEG_W-1:0]  seg;
        logic [PC_W-1:0]   off;
        logic [PL_W-1:0]   min_pl;
    } gate_t;

    localparam int GATE_W = $bits(gate_t);

    typedef struct packed {
        logic [PL_W-1:0]   pl;
        logic [SP_W-1:0]   sp;
        logic [PC_W-1:0]   pc;
        logic [SEG_W-1:0]  seg;
        logic              ie;
    } ctx_t;

    typedef struct packed {
        logic              fault;
        logic [PL_W-1:0]   tgt_pl;
        logic              sw_stack;
        logic              clr_ie;
    } verdict_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CHECK = 3'd1,
        S_STACK = 3'd2,
        S_LOAD  = 3'd3,
        S_DONE  = 3'd4
    } state_e;

    function automatic logic [PL_W-1:0] seg_level(input logic [SEG_W-1:0] s);
        return s[PL_W-1:0];
    endfunction

endpackage

// File: rtl/pgc_regfile.sv
module pgc_regfile #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pgc_check.sv
module pgc_check
    import pgc_pkg::*;
(
    input  op_e              op,
    input  logic [PL_W-1:0]  cur_pl,
    input  gate_t            gate,
    output verdict_t         verdict
);

    logic [PL_W-1:0] gate_tgt;

    assign gate_tgt = seg_level(gate.seg);

    always_comb begin
        verdict = '0;
        unique case (op)
            OP_GATE: begin
                verdict.tgt_pl   = gate_tgt;
                verdict.fault    = (gate.kind == GK_RSVD)
                                 || (cur_pl > gate.min_pl)
                                 || (gate_tgt > cur_pl);
                verdict.sw_stack = (gate_tgt != cur_pl);
                verdict.clr_ie   = (gate.kind == GK_INTR);
            end
            OP_SYSCALL: begin
                verdict.tgt_pl   = '0;
                verdict.sw_stack = 1'b1;
            end
            OP_FRET: begin
                verdict.tgt_pl   = USER_PL;
                verdict.fault    = (cur_pl != '0);
            end
            default: begin
                verdict.fault    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/priv_gate_ctrl.sv
module priv_gate_ctrl
    import pgc_pkg::*;
#(
    parameter int NUM_GATES = 8,
    parameter int GIDX_W    = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [GIDX_W-1:0]  req_gate,
    input  logic [PC_W-1:0]    req_ret_pc,
    input  logic               gate_we,
    input  logic [GIDX_W-1:0]  gate_waddr,
    input  logic [1:0]         gate_kind,
    input  logic [SEG_W-1:0]   gate_seg,
    input  logic [PC_W-1:0]    gate_off,
    input  logic [PL_W-1:0]    gate_min_pl,
    input  logic               stk_we,
    input  logic [PL_W-1:0]    stk_ring,
    input  logic [SP_W-1:0]    stk_wdata,
    input  logic [PC_W-1:0]    syscall_entry,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [PL_W-1:0]    cur_pl,
    output logic [SP_W-1:0]    cur_sp,
    output logic [PC_W-1:0]    cur_pc,
    output logic [SEG_W-1:0]   cur_seg,
    output logic               int_en
);

    state_e              state;
    op_e                 op_q;
    logic [GIDX_W-1:0]   gidx_q;
    logic [PC_W-1:0]     retpc_q;
    verdict_t            verdict_q;
    verdict_t            verdict;
    gkind_e              tkind_q;
    logic [SEG_W-1:0]    tseg_q;
    logic [PC_W-1:0]     toff_q;
    ctx_t                cur;
    ctx_t                shadow;

    gate_t               gate_wr;
    logic [GATE_W-1:0]   gate_rd_bits;
    gate_t               gate_rd;
    logic [SP_W-1:0]     stk_rd;

    assign gate_wr = '{kind: gkind_e'(gate_kind), seg: gate_seg,
                       off: gate_off, min_pl: gate_min_pl};
    assign gate_rd = gate_t'(gate_rd_bits);

    pgc_regfile #(.DEPTH(NUM_GATES), .W(GATE_W), .AW(GIDX_W)) u_gate_tab (
        .clk   (clk),
        .rst   (rst),
        .we    (gate_we),
        .waddr (gate_waddr),
        .wdata (gate_wr),
        .raddr (gidx_q),
        .rdata (gate_rd_bits)
    );

    pgc_regfile #(.DEPTH(NUM_RINGS), .W(SP_W), .AW(PL_W)) u_stk_tab (
        .clk   (clk),
        .rst   (rst),
        .we    (stk_we),
        .waddr (stk_ring),
        .wdata (stk_wdata),
        .raddr (verdict_q.tgt_pl),
        .rdata (stk_rd)
    );

    pgc_check u_check (
        .op      (op_q),
        .cur_pl  (cur.pl),
        .gate    (gate_rd),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            op_q      <= OP_GATE;
            gidx_q    <= '0;
            retpc_q   <= '0;
            verdict_q <= '0;
            tkind_q   <= GK_CALL;
            tseg_q    <= '0;
            toff_q    <= '0;
            cur       <= '0;
            shadow    <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q    <= op_e'(req_op);
                        gidx_q  <= req_gate;
                        retpc_q <= req_ret_pc;
                        state   <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    verdict_q <= verdict;
                    tkind_q   <= gate_rd.kind;
                    tseg_q    <= gate_rd.seg;
                    toff_q    <= gate_rd.off;
                    state     <= verdict.fault ? S_DONE : S_STACK;
                end
                S_STACK: begin
                    if (op_q == OP_GATE || op_q == OP_SYSCALL) begin
                        shadow    <= cur;
                        shadow.pc <= retpc_q;
                        if (verdict_q.sw_stack) begin
                            cur.sp <= stk_rd;
                        end
                    end else begin
                        cur.sp <= shadow.sp;
                    end
                    state <= S_LOAD;
                end
                S_LOAD: begin
                    unique case (op_q)
                        OP_GATE: begin
                            cur.pl  <= verdict_q.tgt_pl;
                            cur.pc  <= toff_q;
                            cur.seg <= tseg_q;
                            if (verdict_q.clr_ie) begin
                                cur.ie <= 1'b0;
                            end
                        end
                        OP_SYSCALL: begin
                            cur.pl  <= '0;
                            cur.pc  <= syscall_entry;
                            cur.seg <= KERNEL_SEG;
                        end
                        OP_FRET: begin
                            cur.pl  <= USER_PL;
                            cur.pc  <= shadow.pc;
                            cur.seg <= USER_SEG;
                            cur.ie  <= 1'b1;
                        end
                        default: begin
                            cur.pl  <= shadow.pl;
                            cur.pc  <= shadow.pc;
                            cur.seg <= shadow.seg;
                            cur.ie  <= shadow.ie;
                        end
                    endcase
                    state <= S_DONE;
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end

    assign busy    = (state == S_CHECK) || (state == S_STACK) || (state == S_LOAD);
    assign done    = (state == S_DONE);
    assign fault   = done && verdict_q.fault;
    assign cur_pl  = cur.pl;
    assign cur_sp  = cur.sp;
    assign cur_pc  = cur.pc;
    assign cur_seg = cur.seg;
    assign int_en  = cur.ie;

    // R1: a refused request leaves the whole context untouched
    assert_fault_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        (state == S_CHECK && verdict.fault) |=> $stable(cur));

    // R2: interrupt gate masks interrupts
    assert_intr_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOAD && op_q == OP_GATE && tkind_q == GK_INTR) |=> !int_en);

    // R2: call and trap gates keep the flag
    assert_trap_keep_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOAD && op_q == OP_GATE && tkind_q != GK_INTR) |=> $stable(int_en));

    // R4: same-ring entry keeps the stack pointer
    assert_same_ring_sp_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_STACK && op_q == OP_GATE && seg_level(tseg_q) == cur.pl) |=> $stable(cur_sp));

    // R6: fast system call lands at level 0 on the configured entry
    assert_syscall_land_R6: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOAD && op_q == OP_SYSCALL) |=> (cur_pl == '0 && cur_pc == $past(syscall_entry)));

    // R7: fast return lands at level 3
    assert_fret_level_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOAD && op_q == OP_FRET) |=> (cur_pl == USER_PL && int_en));

    // R8: level changes only on the load step
    assert_level_only_load_R8: assert property (@(posedge clk) disable iff (rst)
        (state != S_LOAD) |=> $stable(cur_pl));

    // R8: done is a single pulse followed by idle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R8: an idle request starts the busy window
    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && req_valid) |=> busy);

endmodule

// File: tb/priv_gate_ctrl_bench.sv
`timescale 1ns/1ps
module priv_gate_ctrl_bench;
    import pgc_pkg::*;

    localparam int NG = 8;
    localparam int GW = 3;
    localparam logic [31:0] SC_ENTRY = 32'h0000_8000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [GW-1:0] req_gate = '0;
    logic [31:0] req_ret_pc = '0;
    logic gate_we = 1'b0;
    logic [GW-1:0] gate_waddr = '0;
    logic [1:0] gate_kind = '0;
    logic [15:0] gate_seg = '0;
    logic [31:0] gate_off = '0;
    logic [1:0] gate_min_pl = '0;
    logic stk_we = 1'b0;
    logic [1:0] stk_ring = '0;
    logic [31:0] stk_wdata = '0;
    logic busy, done, fault, int_en;
    logic [1:0] cur_pl;
    logic [31:0] cur_sp, cur_pc;
    logic [15:0] cur_seg;

    always #2.5 clk = ~clk;

    priv_gate_ctrl #(.NUM_GATES(NG)) u_priv_gate_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_gate(req_gate), .req_ret_pc(req_ret_pc), .gate_we(gate_we),
        .gate_waddr(gate_waddr), .gate_kind(gate_kind), .gate_seg(gate_seg),
        .gate_off(gate_off), .gate_min_pl(gate_min_pl), .stk_we(stk_we),
        .stk_ring(stk_ring), .stk_wdata(stk_wdata), .syscall_entry(SC_ENTRY),
        .busy(busy), .done(done), .fault(fault), .cur_pl(cur_pl),
        .cur_sp(cur_sp), .cur_pc(cur_pc), .cur_seg(cur_seg), .int_en(int_en)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0]  pl;
        logic [31:0] sp;
        logic [31:0] pc;
        logic [15:0] seg;
        logic        ie;
        logic        flt;
        int          busy_n;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // reference model state, built from the requirements
    logic [1:0]  m_pl = '0, s_pl = '0;
    logic [31:0] m_sp = '0, s_sp = '0, m_pc = '0, s_pc = '0;
    logic [15:0] m_seg = '0, s_seg = '0;
    logic        m_ie = 1'b0, s_ie = 1'b0;
    logic [1:0]  t_kind [NG];
    logic [15:0] t_seg [NG];
    logic [31:0] t_off [NG];
    logic [1:0]  t_min [NG];
    logic [31:0] t_stk [4];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int busy_cnt = 0;

    // monitor: pops expected results on each done pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(fault == e.flt, {e.tag, " fault"}, 32'(fault), 32'(e.flt));
                    chk(cur_pl == e.pl, {e.tag, " level"}, 32'(cur_pl), 32'(e.pl));
                    chk(cur_sp == e.sp, {e.tag, " sp"}, cur_sp, e.sp);
                    chk(cur_pc == e.pc, {e.tag, " pc"}, cur_pc, e.pc);
                    chk(cur_seg == e.seg, {e.tag, " seg"}, 32'(cur_seg), 32'(e.seg));
                    chk(int_en == e.ie, {e.tag, " ie"}, 32'(int_en), 32'(e.ie));
                    chk(busy_cnt == e.busy_n, {e.tag, " R8 busy cycles"}, 32'(busy_cnt), 32'(e.busy_n));
                end
                busy_cnt = 0;
            end
        end
    end

    task automatic wr_gate(input int idx, input logic [1:0] k, input logic [15:0] sg,
                           input logic [31:0] of, input logic [1:0] mn);
        @(negedge clk);
        gate_we = 1'b1; gate_waddr = GW'(idx); gate_kind = k;
        gate_seg = sg; gate_off = of; gate_min_pl = mn;
        t_kind[idx] = k; t_seg[idx] = sg; t_off[idx] = of; t_min[idx] = mn;
        @(negedge clk);
        gate_we = 1'b0;
    endtask

    task automatic wr_stk(input int ring, input logic [31:0] v);
        @(negedge clk);
        stk_we = 1'b1; stk_ring = 2'(ring); stk_wdata = v;
        t_stk[ring] = v;
        @(negedge clk);
        stk_we = 1'b0;
    endtask

    task automatic save_ctx(input logic [31:0] rp);
        s_pl = m_pl; s_sp = m_sp; s_pc = rp; s_seg = m_seg; s_ie = m_ie;
    endtask

    // driver: predicts the outcome, queues it, then issues the request
    task automatic do_op(input logic [1:0] op, input int g, input logic [31:0] rp,
                         input string tag, input bit poke);
        exp_t e;
        bit f;
        logic [1:0] tgt;
        f = 1'b0;
        case (op)
            2'd0: begin
                tgt = t_seg[g][1:0];
                f = (t_kind[g] == 2'd3) || (m_pl > t_min[g]) || (tgt > m_pl);
                if (!f) begin
                    save_ctx(rp);
                    if (tgt != m_pl) m_sp = t_stk[tgt];
                    m_pl = tgt; m_pc = t_off[g]; m_seg = t_seg[g];
                    if (t_kind[g] == 2'd1) m_ie = 1'b0;
                end
            end
            2'd1: begin
                save_ctx(rp);
                m_sp = t_stk[0]; m_pl = 2'd0; m_pc = SC_ENTRY; m_seg = 16'h0008;
            end
            2'd2: begin
                f = (m_pl != 2'd0);
                if (!f) begin
                    m_sp = s_sp; m_pl = 2'd3; m_pc = s_pc; m_seg = 16'h001B; m_ie = 1'b1;
                end
            end
            default: begin
                m_sp = s_sp; m_pl = s_pl; m_pc = s_pc; m_seg = s_seg; m_ie = s_ie;
            end
        endcase
        e.pl = m_pl; e.sp = m_sp; e.pc = m_pc; e.seg = m_seg; e.ie = m_ie;
        e.flt = f; e.busy_n = f ? 1 : 3; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_gate = GW'(g); req_ret_pc = rp;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b1; req_op = 2'd1; req_ret_pc = 32'hDEAD_0000;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(cur_pl == 0, "R9 level", 32'(cur_pl), 0);
        chk(cur_sp == 0, "R9 sp", cur_sp, 0);
        chk(cur_pc == 0, "R9 pc", cur_pc, 0);
        chk(cur_seg == 0, "R9 seg", 32'(cur_seg), 0);
        chk(int_en == 0, "R9 ie", 32'(int_en), 0);
        chk(!busy && !done && !fault, "R9 handshake", {29'd0, busy, done, fault}, 0);

        wr_stk(0, 32'h1000_0000);
        wr_stk(1, 32'h1100_0000);
        wr_stk(2, 32'h1200_0000);
        wr_stk(3, 32'h1300_0000);
        wr_gate(0, 2'd0, 16'h0008, 32'h0000_0100, 2'd3); // call to ring 0
        wr_gate(1, 2'd1, 16'h0008, 32'h0000_0200, 2'd3); // interrupt to ring 0
        wr_gate(2, 2'd2, 16'h0010, 32'h0000_0300, 2'd3); // trap to ring 0
        wr_gate(3, 2'd0, 16'h0008, 32'h0000_0400, 2'd0); // kernel-only call
        wr_gate(4, 2'd3, 16'h0008, 32'h0000_0450, 2'd3); // reserved kind
        wr_gate(5, 2'd0, 16'h000B, 32'h0000_0500, 2'd3); // call to ring 3
        wr_gate(6, 2'd0, 16'h0009, 32'h0000_0600, 2'd2); // call to ring 1, min 2
        wr_gate(7, 2'd1, 16'h0009, 32'h0000_0700, 2'd3); // interrupt to ring 1

        do_op(2'd0, 3, 32'hA000_0001, "R4 same-level gate keeps sp", 1'b1);
        do_op(2'd2, 0, 32'h0, "R7 fast return to level 3", 1'b0);
        do_op(2'd0, 0, 32'hA000_0002, "R3 call gate entry", 1'b1);
        do_op(2'd3, 0, 32'h0, "R5 general return", 1'b0);
        do_op(2'd0, 1, 32'hA000_0003, "R2 interrupt gate clears ie", 1'b0);
        do_op(2'd3, 0, 32'h0, "R5 return restores ie", 1'b0);
        do_op(2'd0, 2, 32'hA000_0004, "R2 trap gate keeps ie", 1'b0);
        do_op(2'd3, 0, 32'h0, "R5 return after trap", 1'b0);
        do_op(2'd0, 3, 32'hA000_0005, "R1 caller level above minimum", 1'b0);
        do_op(2'd0, 4, 32'hA000_0006, "R1 reserved kind", 1'b0);
        do_op(2'd0, 6, 32'hA000_0007, "R1 min level 2 from level 3", 1'b0);
        do_op(2'd0, 7, 32'hA000_0008, "R4 ring 1 stack switch", 1'b0);
        do_op(2'd0, 6, 32'hA000_0009, "R4 ring 1 same level", 1'b0);
        do_op(2'd3, 0, 32'h0, "R5 return to ring 1", 1'b0);
        do_op(2'd3, 0, 32'h0, "R5 repeated return", 1'b0);
        do_op(2'd1, 0, 32'hA000_000A, "R6 fast syscall", 1'b1);
        do_op(2'd0, 5, 32'hA000_000B, "R1 outward target from level 0", 1'b0);
        do_op(2'd2, 0, 32'h0, "R7 fast return after syscall", 1'b0);
        do_op(2'd2, 0, 32'h0, "R7 fast return from level 3 faults", 1'b0);
        do_op(2'd0, 5, 32'hA000_000C, "R3 same-level ring 3 call", 1'b0);
        do_op(2'd1, 0, 32'hA000_000D, "R6 syscall from ring 3", 1'b0);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R8 missing done", 32'(exp_q.size()), 0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule